// File: doc/BRIEF.md
# 16-bit ALU with Flag Update

This block is the arithmetic and logic stage of a 16-bit processor datapath. Each request names one of fifteen operations, picks byte or word width, and supplies two operands, the current status flags and a shift count. The block returns three things: the result, a flag that says whether the result should be written back, and the next value of the status flags. Each operation writes only the flags it is defined to change. Every other flag bit passes through from the incoming value.

Requests enter on a valid/ready handshake and results leave on a second valid/ready handshake. One register stage sits between them. The input is ready whenever the output register is empty or is being drained in the same cycle. A result held under back-pressure stays fixed until the consumer takes it. Operand A is the destination and the operand of single-operand operations. Operand B is the source. Instruction decoding, the register file and memory access belong to neighbouring blocks.

Top module: `alu16_flags`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted on a clock edge appears on the outputs with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, the outputs do not change.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, CMP=3, INC=4, DEC=5, AND=6, OR=7, XOR=8, TEST=9, NOT=10, SHL=11, SHR=12, ROL=13, ROR=14 and 15=no-op. With `in_word` low, only the low 8 bits of each operand are used and the upper 8 result bits are 0. In that mode the sign comes from bit 7 and the carry is taken out of bit 7.
- R3: ADD, ADC and SUB compute A+B, A+B+CF and A-B. They update CF, OF, SF, ZF, AF and PF. CF is the carry or borrow out of the top bit. OF is signed overflow.
- R4: CMP sets the flags exactly as SUB does and holds `out_wr` low.
- R5: INC and DEC compute A+1 and A-1 and update OF, SF, ZF, AF and PF. CF keeps its incoming value.
- R6: Flag bit order is [5]=OF, [4]=SF, [3]=ZF, [2]=AF, [1]=PF, [0]=CF. PF is 1 when the low 8 result bits hold an even number of ones. AF is the carry or borrow out of bit 3. ZF is 1 for a zero result.
- R7: AND, OR, XOR and TEST clear CF and OF, set SF, ZF and PF from the result, and keep AF. TEST holds `out_wr` low.
- R8: NOT returns the bitwise inverse of A and leaves every flag unchanged. Code 15 returns A, holds `out_wr` low and leaves every flag unchanged.
- R9: SHL and SHR shift A by the count and fill the vacated bits with 0. CF takes the last bit shifted out. SF, ZF and PF follow the result and AF is kept. For SHL, OF is the result's top bit XOR CF. For SHR, OF is the top bit of A.
- R10: ROL and ROR rotate A by the count and copy the last rotated bit into CF. For ROL, OF is the result's top bit XOR CF. For ROR, OF is the XOR of the result's two top bits. No other flag changes.
- R11: A shift or rotate with a count of 0 returns A, leaves every flag unchanged and still asserts `out_wr`.
- R12: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_op | input | 4 | Operation code |
| in_word | input | 1 | 1 = word width, 0 = byte width |
| in_a | input | DATA_W | Destination / single operand |
| in_b | input | DATA_W | Source operand |
| in_flags | input | 6 | Incoming status flags |
| in_count | input | CNT_W | Shift or rotate count |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_result | output | DATA_W | Result value |
| out_wr | output | 1 | Result should be written back |
| out_flags | output | 6 | Next status flags |

## Verification
The bench builds the block with its defaults, DATA_W=16 and CNT_W=5. With these values a count can reach 31. That exceeds both the byte and the word width, so the tests include shifts that clear the operand completely and rotates that wrap around more than once. The consumer stalls in a fixed irregular pattern, so back-pressure holds results over one or more cycles while requests keep arriving. Directed vectors cover the carry, borrow, overflow, parity and auxiliary-carry boundaries in both widths. A pseudo-random stream then covers every operation code.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_TEST = 4'd9,
    OP_NOT  = 4'd10,
    OP_SHL  = 4'd11,
    OP_SHR  = 4'd12,
    OP_ROL  = 4'd13,
    OP_ROR  = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         word,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cry,
  output logic         aux,
  output logic         ovf
);
  localparam int BW = W / 2;

  logic [W:0] t;
  logic       am, bm, rm;

  always_comb begin
    if (sub) t = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     t = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    res = word ? t[W-1:0] : {{(W-BW){1'b0}}, t[BW-1:0]};
    cry = word ? t[W] : t[BW];
    aux = a[4] ^ b[4] ^ t[4];
    am  = word ? a[W-1] : a[BW-1];
    bm  = word ? b[W-1] : b[BW-1];
    rm  = word ? t[W-1] : t[BW-1];
    ovf = sub ? ((am != bm) && (rm != am)) : ((am == bm) && (rm != am));
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic import alu16_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_TEST: res = a & b;
      OP_OR:           res = a | b;
      OP_XOR:          res = a ^ b;
      default:         res = ~a;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift import alu16_pkg::*; #(
  parameter int W     = 16,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     a,
  input  logic             word,
  input  alu_op_e          op,
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     res,
  output logic             cry,
  output logic             ovf
);
  localparam int BW    = W / 2;
  localparam int STEPS = (1 << CNT_W) - 1;
  localparam logic [W-1:0] BMASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  logic [W-1:0] v, mk, topbit;
  logic         c;
  int           hi;

  always_comb begin
    hi     = word ? W - 1 : BW - 1;
    mk     = word ? '1 : BMASK;
    topbit = word ? {1'b1, {(W-1){1'b0}}} : {{(W-BW){1'b0}}, 1'b1, {(BW-1){1'b0}}};
    v      = a;
    c      = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (i < int'(cnt)) begin
        case (op)
          OP_SHL: begin c = v[hi]; v = (v << 1) & mk; end
          OP_SHR: begin c = v[0];  v = v >> 1; end
          OP_ROL: begin c = v[hi]; v = ((v << 1) | (v >> hi)) & mk; end
          OP_ROR: begin c = v[0];  v = (v >> 1) | (c ? topbit : '0); end
          default: ;
        endcase
      end
    end
    res = v;
    cry = c;
    case (op)
      OP_SHR:  ovf = a[hi];
      OP_ROR:  ovf = v[hi] ^ v[hi-1];
      default: ovf = v[hi] ^ c;
    endcase
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags import alu16_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic              in_word,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [CNT_W-1:0]  in_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr,
  output logic [FLAG_W-1:0] out_flags
);
  localparam int BYTE_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  alu_op_e           op;
  alu_flags_t        fin, nfl;
  logic [DATA_W-1:0] msk, a_m, b_m, src, nres;
  logic [DATA_W-1:0] ar_res, lg_res, sh_res;
  logic              ar_cry, ar_aux, ar_ovf, sh_cry, sh_ovf;
  logic              is_sub, cin, nwr;

  assign op       = alu_op_e'(in_op);
  assign fin      = alu_flags_t'(in_flags);
  assign msk      = in_word ? '1 : BYTE_MASK;
  assign a_m      = in_a & msk;
  assign b_m      = in_b & msk;
  assign is_sub   = (op == OP_SUB) || (op == OP_CMP) || (op == OP_DEC);
  assign src      = ((op == OP_INC) || (op == OP_DEC)) ? DATA_W'(1) : b_m;
  assign cin      = (op == OP_ADC) && fin.cry;
  assign in_ready = !out_valid || out_ready;

  alu16_arith #(.W(DATA_W)) u_arith (
    .a(a_m), .b(src), .word(in_word), .sub(is_sub), .cin(cin),
    .res(ar_res), .cry(ar_cry), .aux(ar_aux), .ovf(ar_ovf)
  );

  alu16_logic #(.W(DATA_W)) u_logic (
    .a(a_m), .b(b_m), .op(op), .res(lg_res)
  );

  alu16_shift #(.W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .a(a_m), .word(in_word), .op(op), .cnt(in_count),
    .res(sh_res), .cry(sh_cry), .ovf(sh_ovf)
  );

  function automatic alu_flags_t put_szp(alu_flags_t f, logic [DATA_W-1:0] r, logic w);
    alu_flags_t o;
    o     = f;
    o.sgn = w ? r[DATA_W-1] : r[BYTE_W-1];
    o.zro = (r == '0);
    o.par = ~^r[BYTE_W-1:0];
    return o;
  endfunction

  always_comb begin
    nres = a_m;
    nwr  = 1'b1;
    nfl  = fin;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_INC, OP_DEC: begin
        nres    = ar_res;
        nfl.aux = ar_aux;
        nfl.ovf = ar_ovf;
        if ((op != OP_INC) && (op != OP_DEC)) nfl.cry = ar_cry;
        nfl = put_szp(nfl, ar_res, in_word);
        if (op == OP_CMP) nwr = 1'b0;
      end
      OP_AND, OP_OR, OP_XOR, OP_TEST: begin
        nres    = lg_res;
        nfl.cry = 1'b0;
        nfl.ovf = 1'b0;
        nfl = put_szp(nfl, lg_res, in_word);
        if (op == OP_TEST) nwr = 1'b0;
      end
      OP_NOT: nres = lg_res & msk;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        if (in_count != '0) begin
          nres    = sh_res;
          nfl.cry = sh_cry;
          nfl.ovf = sh_ovf;
          if ((op == OP_SHL) || (op == OP_SHR)) nfl = put_szp(nfl, sh_res, in_word);
        end
      end
      default: nwr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
      out_flags  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nres;
        out_wr     <= nwr;
        out_flags  <= nfl;
      end
    end
  end
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk import alu16_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              in_word,
  input logic [FLAG_W-1:0] in_flags,
  input logic [CNT_W-1:0]  in_count,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr,
  input logic [FLAG_W-1:0] out_flags
);
  localparam int BYTE_W = DATA_W / 2;

  logic acc, is_shift;
  assign acc      = in_valid && in_ready;
  assign is_shift = (in_op >= 4'd11) && (in_op <= 4'd14);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wr) && $stable(out_flags)) else $error("stall hold"); // R1

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid) else $error("accept to valid"); // R1

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_word |=> out_result[DATA_W-1:BYTE_W] == '0) else $error("byte upper"); // R2

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd3 |=> !out_wr) else $error("cmp write"); // R4

  AST_INCDEC_KEEP_CF: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd4 || in_op == 4'd5) |=> out_flags[0] == $past(in_flags[0])) else $error("incdec cf"); // R5

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op >= 4'd6 && in_op <= 4'd9 |=> !out_flags[0] && !out_flags[5]) else $error("logic clear"); // R7

  AST_NOT_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd10 |=> out_flags == $past(in_flags) && out_wr) else $error("not flags"); // R8

  AST_ROT_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd13 || in_op == 4'd14) |=> out_flags[4:1] == $past(in_flags[4:1])) else $error("rot flags"); // R10

  AST_ZERO_COUNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_shift && in_count == '0 |=> out_flags == $past(in_flags) && out_wr) else $error("zero count"); // R11
endmodule

bind alu16_flags alu16_flags_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_word(in_word), .in_flags(in_flags), .in_count(in_count),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_wr(out_wr), .out_flags(out_flags)
);

// File: tb/tb_alu16_flags.sv
module tb_alu16_flags;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = 4'd0;
  logic        in_word = 1'b1;
  logic [15:0] in_a = 16'd0;
  logic [15:0] in_b = 16'd0;
  logic [5:0]  in_flags = 6'd0;
  logic [4:0]  in_count = 5'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic        out_wr;
  logic [5:0]  out_flags;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] q_res[$];
  logic        q_wr[$];
  logic [5:0]  q_fl[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_flags dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_a(in_a), .in_b(in_b),
    .in_flags(in_flags), .in_count(in_count), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wr(out_wr),
    .out_flags(out_flags)
  );

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2: return "R3";
      4'd3:             return "R4";
      4'd4, 4'd5:       return "R5";
      4'd6, 4'd7, 4'd8, 4'd9: return "R7";
      4'd10, 4'd15:     return "R8";
      4'd11, 4'd12:     return "R9";
      default:          return "R10";
    endcase
  endfunction

  // Reference model built from the requirements; flags [5]=OF [4]=SF [3]=ZF [2]=AF [1]=PF [0]=CF
  function automatic void model(input logic [3:0] op, input logic word,
                                input logic [15:0] a, input logic [15:0] b,
                                input logic [5:0] fl, input logic [4:0] cnt,
                                output logic [15:0] r, output logic wr, output logic [5:0] fo);
    logic [15:0] m, av, bv, src, v;
    logic [16:0] t;
    logic        c;
    int          hb;
    m  = word ? 16'hFFFF : 16'h00FF;
    hb = word ? 15 : 7;
    av = a & m;
    bv = b & m;
    fo = fl;
    wr = 1'b1;
    r  = av;
    c  = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd4: begin
        src = (op == 4'd4) ? 16'd1 : bv;
        t = {1'b0, av} + {1'b0, src} + ((op == 4'd1) ? {16'd0, fl[0]} : 17'd0);
        r = t[15:0] & m;
        if (op != 4'd4) fo[0] = word ? t[16] : t[8];
        fo[5] = (av[hb] == src[hb]) && (r[hb] != av[hb]);
        fo[2] = av[4] ^ src[4] ^ r[4];
        fo[4] = r[hb]; fo[3] = (r == 16'd0); fo[1] = ~^r[7:0];
      end
      4'd2, 4'd3, 4'd5: begin
        src = (op == 4'd5) ? 16'd1 : bv;
        t = {1'b0, av} - {1'b0, src};
        r = t[15:0] & m;
        if (op != 4'd5) fo[0] = word ? t[16] : t[8];
        fo[5] = (av[hb] != src[hb]) && (r[hb] != av[hb]);
        fo[2] = av[4] ^ src[4] ^ r[4];
        fo[4] = r[hb]; fo[3] = (r == 16'd0); fo[1] = ~^r[7:0];
        if (op == 4'd3) wr = 1'b0;
      end
      4'd6, 4'd7, 4'd8, 4'd9: begin
        if (op == 4'd7)      r = av | bv;
        else if (op == 4'd8) r = av ^ bv;
        else                 r = av & bv;
        fo[0] = 1'b0; fo[5] = 1'b0;
        fo[4] = r[hb]; fo[3] = (r == 16'd0); fo[1] = ~^r[7:0];
        if (op == 4'd9) wr = 1'b0;
      end
      4'd10: r = ~av & m;
      4'd11, 4'd12, 4'd13, 4'd14: begin
        if (cnt != 5'd0) begin
          v = av;
          for (int i = 0; i < int'(cnt); i++) begin
            if (op == 4'd11)      begin c = v[hb]; v = (v << 1) & m; end
            else if (op == 4'd12) begin c = v[0];  v = v >> 1; end
            else if (op == 4'd13) begin c = v[hb]; v = {v[14:0], 1'b0} & m; v[0] = c; end
            else                  begin c = v[0];  v = v >> 1; v[hb] = c; end
          end
          r = v;
          fo[0] = c;
          if (op == 4'd12)      fo[5] = av[hb];
          else if (op == 4'd14) fo[5] = r[hb] ^ r[hb-1];
          else                  fo[5] = r[hb] ^ c;
          if (op == 4'd11 || op == 4'd12) begin
            fo[4] = r[hb]; fo[3] = (r == 16'd0); fo[1] = ~^r[7:0];
          end
        end
      end
      default: wr = 1'b0;
    endcase
  endfunction

  task automatic send(input logic [3:0] op, input logic word, input logic [15:0] a,
                      input logic [15:0] b, input logic [5:0] fl, input logic [4:0] cnt,
                      input string tag);
    logic [15:0] er;
    logic        ew;
    logic [5:0]  ef;
    model(op, word, a, b, fl, cnt, er, ew, ef);
    q_res.push_back(er); q_wr.push_back(ew); q_fl.push_back(ef); q_tag.push_back(tag);
    @(negedge clk);
    in_op = op; in_word = word; in_a = a; in_b = b; in_flags = fl; in_count = cnt;
    in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
  endtask

  // Monitor: sets the consumer's ready, checks stall hold and scoreboard order
  initial begin
    int cyc = 0;
    bit prev_stall = 1'b0;
    logic [15:0] p_res;
    logic        p_wr;
    logic [5:0]  p_fl;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !((cyc % 5) == 3 || (cyc % 7) == 0 || (cyc % 11) == 4);
      #1;
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_result !== p_res || out_wr !== p_wr || out_flags !== p_fl) begin
          fails++;
          $display("FAIL R1 stall hold: valid=%b result=%h wr=%b flags=%b, expected valid=1 result=%h wr=%b flags=%b",
                   out_valid, out_result, out_wr, out_flags, p_res, p_wr, p_fl);
        end
      end
      prev_stall = out_valid && !out_ready;
      p_res = out_result; p_wr = out_wr; p_fl = out_flags;
      if (out_valid && out_ready) begin
        checks++;
        if (q_res.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected result=%h, expected no output", out_result);
        end else begin
          logic [15:0] er;
          logic        ew;
          logic [5:0]  ef;
          string       tg;
          er = q_res.pop_front(); ew = q_wr.pop_front(); ef = q_fl.pop_front(); tg = q_tag.pop_front();
          if (out_result !== er || out_wr !== ew || out_flags !== ef) begin
            fails++;
            $display("FAIL %s: result=%h wr=%b flags=%b, expected result=%h wr=%b flags=%b",
                     tg, out_result, out_wr, out_flags, er, ew, ef);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired: pending=%0d, expected 0", q_res.size());
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    #3;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 in reset: valid=%b ready=%b, expected valid=0 ready=1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 after reset: valid=%b ready=%b, expected valid=0 ready=1", out_valid, in_ready);
    end

    send(4'd0, 1'b1, 16'h1234, 16'h1111, 6'b000000, 5'd0, "R3 add word");
    send(4'd0, 1'b1, 16'hFFFF, 16'h0001, 6'b000000, 5'd0, "R3 add carry zero");
    send(4'd1, 1'b1, 16'h7FFF, 16'h0000, 6'b000001, 5'd0, "R3 adc overflow");
    send(4'd0, 1'b0, 16'hAB7F, 16'hCD01, 6'b000000, 5'd0, "R2 byte add overflow");
    send(4'd0, 1'b0, 16'h00FF, 16'h0001, 6'b000000, 5'd0, "R2 byte carry bit7");
    send(4'd2, 1'b1, 16'h0000, 16'h0001, 6'b000000, 5'd0, "R3 sub borrow");
    send(4'd2, 1'b1, 16'h8000, 16'h0001, 6'b000000, 5'd0, "R3 sub overflow");
    send(4'd3, 1'b1, 16'h0042, 16'h0042, 6'b000000, 5'd0, "R4 cmp equal");
    send(4'd4, 1'b1, 16'h000F, 16'h0000, 6'b000001, 5'd0, "R5 inc keeps cf");
    send(4'd5, 1'b0, 16'h0001, 16'h0000, 6'b000000, 5'd0, "R5 dec to zero");
    send(4'd4, 1'b1, 16'hFFFF, 16'h0000, 6'b000000, 5'd0, "R5 inc wrap");
    send(4'd0, 1'b1, 16'h0001, 16'h0002, 6'b000000, 5'd0, "R6 parity even");
    send(4'd0, 1'b1, 16'h0008, 16'h0008, 6'b000000, 5'd0, "R6 aux carry");
    send(4'd6, 1'b1, 16'hF0F0, 16'h0FF0, 6'b111111, 5'd0, "R7 and");
    send(4'd7, 1'b0, 16'h0080, 16'h0001, 6'b111111, 5'd0, "R7 or byte");
    send(4'd8, 1'b1, 16'h5A5A, 16'h5A5A, 6'b100001, 5'd0, "R7 xor self");
    send(4'd9, 1'b1, 16'h8001, 16'h8000, 6'b000101, 5'd0, "R7 test");
    send(4'd10, 1'b1, 16'h00FF, 16'h0000, 6'b101010, 5'd0, "R8 not");
    send(4'd15, 1'b1, 16'h1357, 16'h2468, 6'b010101, 5'd0, "R8 no-op");
    send(4'd11, 1'b0, 16'h00C1, 16'h0000, 6'b000100, 5'd1, "R9 shl byte");
    send(4'd12, 1'b1, 16'h800C, 16'h0000, 6'b000000, 5'd3, "R9 shr word");
    send(4'd11, 1'b1, 16'hFFFF, 16'h0000, 6'b000001, 5'd20, "R9 shl past width");
    send(4'd13, 1'b1, 16'h8001, 16'h0000, 6'b011110, 5'd1, "R10 rol");
    send(4'd14, 1'b0, 16'h0001, 16'h0000, 6'b011110, 5'd1, "R10 ror byte");
    send(4'd13, 1'b0, 16'h0096, 16'h0000, 6'b000000, 5'd31, "R10 rol wrap");
    send(4'd11, 1'b1, 16'hBEEF, 16'h0000, 6'b110011, 5'd0, "R11 shl zero count");
    send(4'd14, 1'b1, 16'hBEEF, 16'h0000, 6'b001100, 5'd0, "R11 ror zero count");

    for (int n = 0; n < 300; n++) begin
      logic [3:0] op;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op = lf[3:0];
      send(op, lf[4], lf[20:5] ^ lf[31:16], lf[15:0] ^ {lf[7:0], lf[31:24]}, lf[26:21], lf[31:27], op_tag(op));
    end

    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 200 && q_res.size() != 0; k++) @(negedge clk);
    if (q_res.size() != 0) begin
      fails++;
      $display("FAIL R1 results missing: pending=%0d, expected 0", q_res.size());
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule